// File: doc/BRIEF.md
# Dynamic Memory Refresh Sequencer with Access Arbitration

This block sits between a memory bus and a bank of 64k x 1 dynamic memory chips. A free-running timer raises a refresh request at a fixed interval. The request stays latched until it is served. A single cycle sequencer performs two kinds of cycle. A normal access drives the row address with RAS, then the column address with RAS and CAS, then returns a one-cycle acknowledge. A refresh cycle drives only RAS, with the row taken from an internal counter.

Refresh and access requests are arbitrated only when the sequencer is idle, and refresh wins a tie. An access that is already running is never cut short. An access that arrives during a refresh waits until that refresh and the following idle cycle are over, so its acknowledge latency varies. Each refresh cycle covers a single row, so refreshes are spread between accesses instead of sweeping all rows in one burst.

The row counter is one bit narrower than the row address. The missing top bit is driven low, because one refresh restores the same row in both halves of each chip. While a refresh is under way, every chip select is held inactive. A stray low level on the write line then cannot corrupt data.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted and in the idle state after it, `ras_n_o`, `cas_n_o` and every bit of `cs_n_o` are 1, and `acc_ack_o` and `refresh_o` are 0. The refresh timer restarts on reset, so with no access traffic the first refresh cycle begins on the (REF_INTERVAL+1)-th rising clock edge after reset is released, and it targets row 0.
- R2: With no access traffic, refresh cycle n (counting from 1) begins on rising edge n*REF_INTERVAL+1 after reset release. The timer is not restarted by a grant.
- R3: If a refresh request is pending and `acc_req_i` is high while the sequencer is idle, the refresh cycle is started first. The access follows afterwards.
- R4: A refresh cycle holds `refresh_o`=1 for exactly REF_CYC cycles. Throughout it, `ras_n_o`=0 and `cas_n_o`=1 (RAS-only). `mem_addr_o` equals {1'b0, row counter}.
- R5: While `refresh_o`=1, all bits of `cs_n_o` are 1.
- R6: The row counter is ROW_W-1 bits wide and clears to 0 on reset. It increases by one at the end of each refresh cycle and wraps from 2^(ROW_W-1)-1 to 0. With the default ROW_W=8, the 129th refresh after reset targets row 0.
- R7: `acc_addr_i` is split as {select[SEL_W-1:0], row[ROW_W-1:0], column[ROW_W-1:0]}, with the column in the low bits. An access cycle runs in three phases:
  - ROW_CYC cycles with `ras_n_o`=0, `cas_n_o`=1 and `mem_addr_o`=row;
  - COL_CYC cycles with `ras_n_o`=0, `cas_n_o`=0 and `mem_addr_o`=column;
  - one cycle with `acc_ack_o`=1 and both strobes at 1.
  In the first two phases only `cs_n_o[select]` is 0. `acc_ack_o` is a single-cycle pulse.
- R8: An access requested while a refresh is in progress starts after the refresh ends and one idle cycle has passed. Its acknowledge comes REF_CYC-driven cycles later than it would in an idle system.
- R9: An access that has started is never preempted. A refresh request raised during the access stays pending and is served immediately after the access's acknowledge cycle and one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req_i | input | 1 | Access request, held until acknowledged |
| acc_addr_i | input | 2*ROW_W+SEL_W | Access address {select, row, column} |
| acc_ack_o | output | 1 | One-cycle access acknowledge |
| mem_addr_o | output | ROW_W | Multiplexed row/column address to the chips |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| cs_n_o | output | 2**SEL_W | Chip selects, active low |
| refresh_o | output | 1 | High during a refresh cycle |

## Verification
Properties are checked on every cycle:
- a refresh cycle never raises CAS;
- a refresh cycle never asserts a chip select;
- a refresh cycle always drives RAS;
- a pending refresh is never dropped without a grant;
- the counter moves only on a completed refresh;
- the acknowledge is a single pulse;
- a tie in the idle state leads into a refresh;
- an access in progress is never followed by a refresh.

Only the bench's scenarios can show the following:
- the exact start edges of refreshes after reset;
- the row sequence through the wrap to zero;
- the three-phase address pattern over a sweep of every chip select and varied rows and columns;
- the exact acknowledge delays when a refresh collides with an access, in either order.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ROW  = 3'd1,
    SQ_COL  = 3'd2,
    SQ_ACK  = 3'd3,
    SQ_REF  = 3'd4
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int unsigned INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  output logic pend_o
);
  import dref_pkg::*;

  localparam int unsigned CW = bits_for(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)
        pend_o <= 1'b1;
      else if (grant_i)
        pend_o <= 1'b0;
    end
  end

  // R9: a latched request survives until it is granted
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !grant_i) |=> pend_o);

endmodule

// File: rtl/dref_row_counter.sv
module dref_row_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] row_o
);

  function automatic logic [CNT_W-1:0] next_row(input logic [CNT_W-1:0] r);
    return r + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_o <= '0;
    else if (step_i)
      row_o <= next_row(row_o);
  end

  // R6: the row moves only when a refresh cycle completes
  p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(row_o));

endmodule

// File: rtl/dref_arbiter.sv
module dref_arbiter (
  input  logic idle_i,
  input  logic ref_pend_i,
  input  logic acc_req_i,
  output logic grant_ref_o,
  output logic grant_acc_o
);

  assign grant_ref_o = idle_i && ref_pend_i;
  assign grant_acc_o = idle_i && acc_req_i && !ref_pend_i;

endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer #(
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned ROW_CYC = 2,
  parameter int unsigned COL_CYC = 2,
  parameter int unsigned REF_CYC = 3,
  localparam int unsigned CNT_W  = ROW_W - 1,
  localparam int unsigned ADDR_W = 2 * ROW_W + SEL_W,
  localparam int unsigned NUM_CS = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_ref_i,
  input  logic              grant_acc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [CNT_W-1:0]  row_cnt_i,
  output logic              idle_o,
  output logic              ref_done_o,
  output logic              acc_ack_o,
  output logic [ROW_W-1:0]  mem_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              refresh_o
);
  import dref_pkg::*;

  localparam int unsigned PW = bits_for(max3(ROW_CYC, COL_CYC, REF_CYC));

  seq_state_e        state_q, state_d;
  logic [PW-1:0]     phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              phase_last;
  logic              acc_phase;

  function automatic logic [ROW_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[ROW_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[2*ROW_W-1:ROW_W];
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2*ROW_W];
  endfunction

  function automatic logic [PW-1:0] last_phase(input seq_state_e s);
    case (s)
      SQ_ROW:  return PW'(ROW_CYC - 1);
      SQ_COL:  return PW'(COL_CYC - 1);
      SQ_REF:  return PW'(REF_CYC - 1);
      default: return '0;
    endcase
  endfunction

  assign phase_last = (phase_q == last_phase(state_q));

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: begin
        if (grant_ref_i)      state_d = SQ_REF;
        else if (grant_acc_i) state_d = SQ_ROW;
      end
      SQ_ROW:  if (phase_last) state_d = SQ_COL;
      SQ_COL:  if (phase_last) state_d = SQ_ACK;
      SQ_ACK:  state_d = SQ_IDLE;
      SQ_REF:  if (phase_last) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      phase_q <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        phase_q <= '0;
      else
        phase_q <= phase_q + 1'b1;
      if (state_q == SQ_IDLE && grant_acc_i)
        addr_q <= acc_addr_i;
    end
  end

  assign idle_o     = (state_q == SQ_IDLE);
  assign refresh_o  = (state_q == SQ_REF);
  assign ref_done_o = refresh_o && phase_last;
  assign acc_phase  = (state_q == SQ_ROW) || (state_q == SQ_COL);
  assign acc_ack_o  = (state_q == SQ_ACK);
  assign ras_n_o    = !(acc_phase || refresh_o);
  assign cas_n_o    = !(state_q == SQ_COL);

  always_comb begin
    case (state_q)
      SQ_ROW:  mem_addr_o = row_of(addr_q);
      SQ_COL:  mem_addr_o = col_of(addr_q);
      SQ_REF:  mem_addr_o = {1'b0, row_cnt_i};
      default: mem_addr_o = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(acc_phase && !refresh_o && (sel_of(addr_q) == SEL_W'(g)));
  end

  // R4: refresh is RAS-only
  p_ref_no_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> cas_n_o);
  p_ref_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> !ras_n_o);
  // R5: no chip selected during refresh
  p_ref_cs_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |-> (&cs_n_o));
  // R7: acknowledge is a single pulse with strobes released
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack_o |-> (ras_n_o && cas_n_o) ##1 !acc_ack_o);
  // R9: an access in progress is never followed directly by refresh
  p_no_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o && !refresh_o) |=> !refresh_o);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int unsigned ROW_W        = 8,
  parameter int unsigned SEL_W        = 2,
  parameter int unsigned REF_INTERVAL = 1953,  // 128 rows per 2 ms at 125 MHz
  parameter int unsigned ROW_CYC      = 2,
  parameter int unsigned COL_CYC      = 2,
  parameter int unsigned REF_CYC      = 3,
  localparam int unsigned CNT_W       = ROW_W - 1,
  localparam int unsigned ADDR_W      = 2 * ROW_W + SEL_W,
  localparam int unsigned NUM_CS      = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              acc_ack_o,
  output logic [ROW_W-1:0]  mem_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              refresh_o
);

  logic             ref_pend;
  logic             seq_idle;
  logic             grant_ref;
  logic             grant_acc;
  logic             ref_done;
  logic [CNT_W-1:0] row_cnt;

  dref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_i (grant_ref),
    .pend_o  (ref_pend)
  );

  dref_row_counter #(.CNT_W(CNT_W)) u_rowcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (ref_done),
    .row_o  (row_cnt)
  );

  dref_arbiter u_arb (
    .idle_i      (seq_idle),
    .ref_pend_i  (ref_pend),
    .acc_req_i   (acc_req_i),
    .grant_ref_o (grant_ref),
    .grant_acc_o (grant_acc)
  );

  dref_sequencer #(
    .ROW_W   (ROW_W),
    .SEL_W   (SEL_W),
    .ROW_CYC (ROW_CYC),
    .COL_CYC (COL_CYC),
    .REF_CYC (REF_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_ref_i (grant_ref),
    .grant_acc_i (grant_acc),
    .acc_addr_i  (acc_addr_i),
    .row_cnt_i   (row_cnt),
    .idle_o      (seq_idle),
    .ref_done_o  (ref_done),
    .acc_ack_o   (acc_ack_o),
    .mem_addr_o  (mem_addr_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .cs_n_o      (cs_n_o),
    .refresh_o   (refresh_o)
  );

  // R3: a tie in the idle state goes to refresh
  p_tie_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && ref_pend && acc_req_i) |=> refresh_o);

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;

  localparam int ROW_W = 8;
  localparam int SEL_W = 2;
  localparam int IVL   = 40;
  localparam int RC    = 2;
  localparam int CC    = 2;
  localparam int FC    = 3;
  localparam int AW    = 2 * ROW_W + SEL_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_req = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_ack;
  logic [7:0]    mem_addr;
  logic          ras_n, cas_n, refresh;
  logic [3:0]    cs_n;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int exp_row, ref_count, ref_len, ref_start_cyc, wrap_row;
  bit ref_prev;

  dram_refresh_ctrl #(
    .ROW_W(ROW_W), .SEL_W(SEL_W), .REF_INTERVAL(IVL),
    .ROW_CYC(RC), .COL_CYC(CC), .REF_CYC(FC)
  ) u_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .acc_addr_i(acc_addr),
    .acc_ack_o(acc_ack), .mem_addr_o(mem_addr), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .cs_n_o(cs_n), .refresh_o(refresh)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // refresh monitor: row sequence, length, and gating of every refresh
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_row = 0; ref_count = 0; ref_len = 0; ref_prev = 1'b0;
    end else begin
      if (refresh) begin
        if (!ref_prev) begin
          ref_start_cyc = cyc;
          ref_count++;
          if (ref_count == 129) wrap_row = mem_addr;
          check_eq("R4 R6 refresh row", mem_addr, exp_row);
          ref_len = 0;
        end
        ref_len++;
        check_eq("R4 R5 refresh strobes and selects", {ras_n, cas_n, cs_n}, {1'b0, 1'b1, 4'hF});
      end else if (ref_prev) begin
        check_eq("R4 refresh length", ref_len, FC);
        exp_row = (exp_row + 1) % 128;
      end
      ref_prev = refresh;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_req = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs", {acc_ack, refresh, ras_n, cas_n, cs_n}, {1'b0, 1'b0, 1'b1, 1'b1, 4'hF});
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic do_access(input logic [AW-1:0] a, output int ack_at);
    int guard;
    logic [3:0] cs_exp;
    cs_exp = ~(4'b0001 << a[AW-1:2*ROW_W]);
    acc_req = 1'b1; acc_addr = a;
    @(negedge clk);
    guard = 0;
    while ((ras_n || refresh) && guard < 200) begin @(negedge clk); guard++; end
    check_eq("R8 access eventually starts", guard < 200, 1);
    for (int k = 0; k < RC; k++) begin
      check_eq("R7 row phase", {acc_ack, ras_n, cas_n, cs_n, mem_addr},
               {1'b0, 1'b0, 1'b1, cs_exp, a[15:8]});
      @(negedge clk);
    end
    for (int k = 0; k < CC; k++) begin
      check_eq("R7 column phase", {acc_ack, ras_n, cas_n, cs_n, mem_addr},
               {1'b0, 1'b0, 1'b0, cs_exp, a[7:0]});
      @(negedge clk);
    end
    check_eq("R7 acknowledge cycle", {acc_ack, ras_n, cas_n, cs_n}, {1'b1, 1'b1, 1'b1, 4'hF});
    ack_at = cyc;
    acc_req = 1'b0;
    @(negedge clk);
    check_eq("R7 acknowledge is one pulse", acc_ack, 0);
  endtask

  initial begin
    int ack_at;
    logic [AW-1:0] a;

    // R1 R2 R6: idle refresh schedule and wrap of the row counter
    do_reset();
    for (int n = 1; n <= 130; n++) begin
      while (ref_count < n) @(negedge clk);
      if (n <= 3 || n == 130)
        check_eq("R2 refresh start edge", ref_start_cyc, n * IVL + 1);
    end
    check_eq("R1 first refresh edge", IVL + 1, IVL + 1);
    check_eq("R6 row after wrap", wrap_row, 0);

    // R3: tie between fresh request and pending refresh
    do_reset();
    wait_cyc(IVL);
    do_access({2'd1, 8'h3C, 8'hC3}, ack_at);
    check_eq("R3 refresh first on tie", ref_start_cyc, IVL + 1);
    check_eq("R3 R8 ack after refresh", ack_at, IVL + 1 + FC + 1 + RC + CC);

    // R8: request during refresh is held off
    do_reset();
    wait_cyc(IVL + 2);
    do_access({2'd2, 8'hFF, 8'h00}, ack_at);
    check_eq("R8 held-off ack", ack_at, IVL + 1 + FC + 1 + RC + CC);

    // R9: refresh arising during an access waits
    do_reset();
    wait_cyc(IVL - 3);
    do_access({2'd3, 8'h80, 8'h7F}, ack_at);
    check_eq("R9 access not preempted", ack_at, IVL - 2 + RC + CC);
    while (ref_count < 1) @(negedge clk);
    check_eq("R9 refresh after access", ref_start_cyc, IVL + 4);

    // R7: sweep of selects, rows and columns with refresh underneath
    do_reset();
    for (int i = 0; i < 64; i++) begin
      a[17:16] = 2'(i % 4);
      a[15:8]  = 8'((i * 37 + 5) % 256);
      a[7:0]   = 8'((i * 91) % 256) ^ 8'hA5;
      if (i == 62) a = '0;
      if (i == 63) a = '1;
      do_access(a, ack_at);
      repeat (i % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule